// File: doc/BRIEF.md
# ASN-tagged fully associative translation buffer

This block caches virtual-to-physical page translations for a processor core. Every entry carries a virtual page tag, a physical page number, an address space number, a global flag, per-privilege read and write enable masks, and fault-on-read and fault-on-write flags. A lookup presents a virtual page and the current address space number. The lookup result is combinational and returns the matching entry and its slot index.

New translations are written into the slot named by a rotating victim pointer. The same pointer can be read out and stepped on its own, so that a walker can inspect or overwrite slots in order. Three invalidation commands are provided: one clears everything, one drops only the entries that are not global, and one drops a single page in one address space. A three-slot list of recent array hits is checked before the main array. Any insert or flush empties this list.

Top module: `asn_tlb`

## Requirements
- R1: An entry matches a lookup only if it is valid, its tag equals `lk_vpn_i`, and either its global flag is set or its stored ASN equals `lk_asn_i`. `hit_o` is high exactly when a match is reported.
- R2: An insert that takes effect writes the slot at `ptr_idx_o` and marks it valid, replacing any earlier contents. The pointer then moves up by one and wraps from N_ENTRIES-1 to 0.
- R3: Flush-all invalidates every slot and sets the victim pointer to 0.
- R4: Flush-non-global invalidates every valid slot whose global flag is 0. Global slots keep their contents.
- R5: Flush-by-address invalidates every slot that would match (R1) the pair `fa_vpn_i`/`fa_asn_i`, and no other slot.
- R6: A lookup first checks recent-hit positions 0, 1, 2 in that order and reports the first one that matches. If none matches, the lowest matching array index is reported. When `lk_valid_i` is high and the hit came from the array, that index enters position 0 and the older positions shift down by one (the oldest is dropped). A hit from the recent-hit list leaves the list unchanged.
- R7: Any of `ins_i`, `flush_all_i`, `flush_ng_i`, `flush_addr_i` high at a clock edge empties the recent-hit list. The effect is observable because duplicate matches then resolve to the lowest index.
- R8: `ptr_valid_o`, `ptr_vpn_o` and `ptr_ppn_o` show the slot at the victim pointer. `adv_i` moves the pointer by one with wraparound, and never by two, even when it coincides with an insert.
- R9: Commands act at the clock edge, and a lookup in the same cycle sees the state before the edge. If several commands are high together, only the first one in the order flush-all, flush-non-global, flush-by-address, insert is applied. A suppressed insert does not move the pointer.
- R10: After reset all slots are invalid, the pointer is 0 and the recent-hit list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup is real; allows the recent-hit list to update |
| lk_vpn_i | input | VPN_W | Lookup virtual page |
| lk_asn_i | input | ASN_W | Lookup address space number |
| hit_o | output | 1 | A match was found |
| hit_idx_o | output | IDX_W | Slot index of the reported match |
| hit_ppn_o | output | PPN_W | Physical page of the reported slot |
| hit_global_o | output | 1 | Global flag of the reported slot |
| hit_rmask_o | output | N_MODES | Read enable per mode of the reported slot |
| hit_wmask_o | output | N_MODES | Write enable per mode of the reported slot |
| hit_frd_o | output | 1 | Fault-on-read flag of the reported slot |
| hit_fwr_o | output | 1 | Fault-on-write flag of the reported slot |
| ins_i | input | 1 | Insert command |
| ins_vpn_i | input | VPN_W | Tag to insert |
| ins_ppn_i | input | PPN_W | Physical page to insert |
| ins_asn_i | input | ASN_W | ASN to insert |
| ins_global_i | input | 1 | Global flag to insert |
| ins_rmask_i | input | N_MODES | Read mask to insert |
| ins_wmask_i | input | N_MODES | Write mask to insert |
| ins_frd_i | input | 1 | Fault-on-read flag to insert |
| ins_fwr_i | input | 1 | Fault-on-write flag to insert |
| flush_all_i | input | 1 | Invalidate all slots |
| flush_ng_i | input | 1 | Invalidate non-global slots |
| flush_addr_i | input | 1 | Invalidate one page in one address space |
| fa_vpn_i | input | VPN_W | Page for flush-by-address |
| fa_asn_i | input | ASN_W | ASN for flush-by-address |
| adv_i | input | 1 | Step the victim pointer |
| ptr_idx_o | output | IDX_W | Victim pointer |
| ptr_valid_o | output | 1 | Valid flag of the slot at the pointer |
| ptr_vpn_o | output | VPN_W | Tag of the slot at the pointer |
| ptr_ppn_o | output | PPN_W | Physical page of the slot at the pointer |

## Verification
The bench targets duplicate matches: one page mapped twice, once global and once under a specific ASN. Ordering of the recent-hit list is only visible in that case. A design that searches the array first, reorders the list on a list hit, or fails to empty the list on a flush would report the wrong slot index. Other cases covered are pointer wraparound, an insert and an advance in the same cycle, and several commands raised together. In those cases a wrong priority or a double step shows up as a wrong pointer or as a surviving entry. A flush-by-address that ignores the global flag, or a flush-non-global that also removes global slots, leaves the later lookups with the wrong hit.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_INSERT,
    CMD_FLUSH_ADDR,
    CMD_FLUSH_NG,
    CMD_FLUSH_ALL
  } tlb_cmd_e;
endpackage

// File: rtl/asn_tlb_match.sv
module asn_tlb_match #(
  parameter int VPN_W = 20,
  parameter int ASN_W = 8
) (
  input  logic             valid_i,
  input  logic             glob_i,
  input  logic [VPN_W-1:0] tag_i,
  input  logic [ASN_W-1:0] asn_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [ASN_W-1:0] req_asn_i,
  output logic             match_o
);
  assign match_o = valid_i && (tag_i == req_vpn_i) && (glob_i || (asn_i == req_asn_i));
endmodule

// File: rtl/asn_tlb_mru.sv
module asn_tlb_mru #(
  parameter int N     = 8,
  parameter int DEPTH = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             lookup_i,
  input  logic [N-1:0]     match_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [DEPTH-1:0] slot_v;
  logic [IDX_W-1:0] slot_idx [DEPTH];
  logic             mru_hit, arr_hit, push;
  logic [IDX_W-1:0] mru_idx, arr_idx;

  always_comb begin
    mru_hit = 1'b0;
    mru_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (slot_v[k] && match_i[slot_idx[k]]) begin
        mru_hit = 1'b1;
        mru_idx = slot_idx[k];
      end
    end
    arr_hit = |match_i;
    arr_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) arr_idx = IDX_W'(i);
    end
  end

  assign hit_o = mru_hit || arr_hit;
  assign idx_o = mru_hit ? mru_idx : arr_idx;
  assign push  = lookup_i && !mru_hit && arr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v <= '0;
      for (int k = 0; k < DEPTH; k++) slot_idx[k] <= '0;
    end else if (clear_i) begin
      slot_v <= '0;
    end else if (push) begin
      slot_v      <= {slot_v[DEPTH-2:0], 1'b1};
      slot_idx[0] <= arr_idx;
      for (int k = 1; k < DEPTH; k++) slot_idx[k] <= slot_idx[k-1];
    end
  end

  // list is filled from the front, so valid bits stay contiguous
  for (genvar k = 1; k < DEPTH; k++) begin : g_contig
    p_list_contig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_v[k] |-> slot_v[k-1]);
  end

  p_list_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !clear_i) |=> (slot_v[0] && slot_idx[0] == $past(arr_idx)));

  p_list_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (slot_v == '0));
endmodule

// File: rtl/asn_tlb_victim.sv
module asn_tlb_victim #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (zero_i)  ptr_o <= '0;
    else if (step_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  p_ptr_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST);

  p_ptr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !zero_i && ptr_o != LAST) |=> (ptr_o == $past(ptr_o) + 1'b1));

  p_ptr_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !zero_i && ptr_o == LAST) |=> (ptr_o == '0));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import asn_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 16,
  parameter int ASN_W     = 8,
  parameter int N_MODES   = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  input  logic [ASN_W-1:0]   lk_asn_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [PPN_W-1:0]   hit_ppn_o,
  output logic               hit_global_o,
  output logic [N_MODES-1:0] hit_rmask_o,
  output logic [N_MODES-1:0] hit_wmask_o,
  output logic               hit_frd_o,
  output logic               hit_fwr_o,
  input  logic               ins_i,
  input  logic [VPN_W-1:0]   ins_vpn_i,
  input  logic [PPN_W-1:0]   ins_ppn_i,
  input  logic [ASN_W-1:0]   ins_asn_i,
  input  logic               ins_global_i,
  input  logic [N_MODES-1:0] ins_rmask_i,
  input  logic [N_MODES-1:0] ins_wmask_i,
  input  logic               ins_frd_i,
  input  logic               ins_fwr_i,
  input  logic               flush_all_i,
  input  logic               flush_ng_i,
  input  logic               flush_addr_i,
  input  logic [VPN_W-1:0]   fa_vpn_i,
  input  logic [ASN_W-1:0]   fa_asn_i,
  input  logic               adv_i,
  output logic [IDX_W-1:0]   ptr_idx_o,
  output logic               ptr_valid_o,
  output logic [VPN_W-1:0]   ptr_vpn_o,
  output logic [PPN_W-1:0]   ptr_ppn_o
);
  typedef struct packed {
    logic               valid;
    logic               glob;
    logic [VPN_W-1:0]   vpn;
    logic [PPN_W-1:0]   ppn;
    logic [ASN_W-1:0]   asn;
    logic [N_MODES-1:0] rmask;
    logic [N_MODES-1:0] wmask;
    logic               f_rd;
    logic               f_wr;
  } entry_t;

  entry_t                 table_q [N_ENTRIES];
  entry_t                 new_entry;
  entry_t                 sel_e, ptr_e;
  tlb_cmd_e               cmd;
  logic [N_ENTRIES-1:0]   lk_match, fa_match, vld_vec, glob_vec;

  // single command per edge, fixed priority
  always_comb begin
    if (flush_all_i)       cmd = CMD_FLUSH_ALL;
    else if (flush_ng_i)   cmd = CMD_FLUSH_NG;
    else if (flush_addr_i) cmd = CMD_FLUSH_ADDR;
    else if (ins_i)        cmd = CMD_INSERT;
    else                   cmd = CMD_NONE;
  end

  always_comb begin
    new_entry       = '0;
    new_entry.valid = 1'b1;
    new_entry.glob  = ins_global_i;
    new_entry.vpn   = ins_vpn_i;
    new_entry.ppn   = ins_ppn_i;
    new_entry.asn   = ins_asn_i;
    new_entry.rmask = ins_rmask_i;
    new_entry.wmask = ins_wmask_i;
    new_entry.f_rd  = ins_frd_i;
    new_entry.f_wr  = ins_fwr_i;
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    assign vld_vec[i]  = table_q[i].valid;
    assign glob_vec[i] = table_q[i].glob;

    asn_tlb_match #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
      .valid_i   (table_q[i].valid),
      .glob_i    (table_q[i].glob),
      .tag_i     (table_q[i].vpn),
      .asn_i     (table_q[i].asn),
      .req_vpn_i (lk_vpn_i),
      .req_asn_i (lk_asn_i),
      .match_o   (lk_match[i])
    );

    asn_tlb_match #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_fa_match (
      .valid_i   (table_q[i].valid),
      .glob_i    (table_q[i].glob),
      .tag_i     (table_q[i].vpn),
      .asn_i     (table_q[i].asn),
      .req_vpn_i (fa_vpn_i),
      .req_asn_i (fa_asn_i),
      .match_o   (fa_match[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) table_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        case (cmd)
          CMD_FLUSH_ALL:  table_q[i] <= '0;
          CMD_FLUSH_NG:   if (!table_q[i].glob) table_q[i].valid <= 1'b0;
          CMD_FLUSH_ADDR: if (fa_match[i]) table_q[i].valid <= 1'b0;
          CMD_INSERT:     if (ptr_idx_o == IDX_W'(i)) table_q[i] <= new_entry;
          default: ;
        endcase
      end
    end
  end

  asn_tlb_mru #(.N(N_ENTRIES), .DEPTH(3)) u_mru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (ins_i || flush_all_i || flush_ng_i || flush_addr_i),
    .lookup_i (lk_valid_i),
    .match_i  (lk_match),
    .hit_o    (hit_o),
    .idx_o    (hit_idx_o)
  );

  asn_tlb_victim #(.N(N_ENTRIES)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .zero_i (cmd == CMD_FLUSH_ALL),
    .step_i ((cmd == CMD_INSERT) || adv_i),
    .ptr_o  (ptr_idx_o)
  );

  assign sel_e        = table_q[hit_idx_o];
  assign hit_ppn_o    = sel_e.ppn;
  assign hit_global_o = sel_e.glob;
  assign hit_rmask_o  = sel_e.rmask;
  assign hit_wmask_o  = sel_e.wmask;
  assign hit_frd_o    = sel_e.f_rd;
  assign hit_fwr_o    = sel_e.f_wr;

  assign ptr_e       = table_q[ptr_idx_o];
  assign ptr_valid_o = ptr_e.valid;
  assign ptr_vpn_o   = ptr_e.vpn;
  assign ptr_ppn_o   = ptr_e.ppn;

  p_hit_is_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (sel_e.valid && sel_e.vpn == lk_vpn_i && (sel_e.glob || sel_e.asn == lk_asn_i)));

  p_insert_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_INSERT) |=> vld_vec[$past(ptr_idx_o)]);

  p_flush_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_FLUSH_ALL) |=> (vld_vec == '0 && ptr_idx_o == '0));

  p_flush_ng_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_FLUSH_NG) |=> ((vld_vec & ~glob_vec) == '0));

  p_flush_ng_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_FLUSH_NG) |=> ((vld_vec & glob_vec) == $past(vld_vec & glob_vec)));

  p_flush_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_FLUSH_ADDR) |=> ((vld_vec & $past(fa_match)) == '0));
endmodule

// File: tb/asn_tlb_bench.sv
`timescale 1ns/100ps
module asn_tlb_bench;
  localparam int N = 8;
  localparam int VPN_W = 20, PPN_W = 16, ASN_W = 8, N_MODES = 4;
  localparam int IDX_W = $clog2(N);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic               lk_valid_i = 0;
  logic [VPN_W-1:0]   lk_vpn_i = 0;
  logic [ASN_W-1:0]   lk_asn_i = 0;
  logic               hit_o;
  logic [IDX_W-1:0]   hit_idx_o;
  logic [PPN_W-1:0]   hit_ppn_o;
  logic               hit_global_o;
  logic [N_MODES-1:0] hit_rmask_o, hit_wmask_o;
  logic               hit_frd_o, hit_fwr_o;
  logic               ins_i = 0;
  logic [VPN_W-1:0]   ins_vpn_i = 0;
  logic [PPN_W-1:0]   ins_ppn_i = 0;
  logic [ASN_W-1:0]   ins_asn_i = 0;
  logic               ins_global_i = 0;
  logic [N_MODES-1:0] ins_rmask_i = 0, ins_wmask_i = 0;
  logic               ins_frd_i = 0, ins_fwr_i = 0;
  logic               flush_all_i = 0, flush_ng_i = 0, flush_addr_i = 0;
  logic [VPN_W-1:0]   fa_vpn_i = 0;
  logic [ASN_W-1:0]   fa_asn_i = 0;
  logic               adv_i = 0;
  logic [IDX_W-1:0]   ptr_idx_o;
  logic               ptr_valid_o;
  logic [VPN_W-1:0]   ptr_vpn_o;
  logic [PPN_W-1:0]   ptr_ppn_o;

  asn_tlb u_asn_tlb (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_vpn_i(lk_vpn_i), .lk_asn_i(lk_asn_i),
    .hit_o(hit_o), .hit_idx_o(hit_idx_o), .hit_ppn_o(hit_ppn_o),
    .hit_global_o(hit_global_o), .hit_rmask_o(hit_rmask_o), .hit_wmask_o(hit_wmask_o),
    .hit_frd_o(hit_frd_o), .hit_fwr_o(hit_fwr_o),
    .ins_i(ins_i), .ins_vpn_i(ins_vpn_i), .ins_ppn_i(ins_ppn_i), .ins_asn_i(ins_asn_i),
    .ins_global_i(ins_global_i), .ins_rmask_i(ins_rmask_i), .ins_wmask_i(ins_wmask_i),
    .ins_frd_i(ins_frd_i), .ins_fwr_i(ins_fwr_i),
    .flush_all_i(flush_all_i), .flush_ng_i(flush_ng_i), .flush_addr_i(flush_addr_i),
    .fa_vpn_i(fa_vpn_i), .fa_asn_i(fa_asn_i), .adv_i(adv_i),
    .ptr_idx_o(ptr_idx_o), .ptr_valid_o(ptr_valid_o), .ptr_vpn_o(ptr_vpn_o),
    .ptr_ppn_o(ptr_ppn_o)
  );

  // behavioural reference
  bit m_v [N];
  bit m_g [N];
  int m_vpn [N], m_ppn [N], m_asn [N], m_rm [N];
  int m_ptr;
  int mru [$];

  int checks = 0, errors = 0;
  string cur_req = "R10";

  function automatic bit m_match(int i, int vpn, int asn);
    return m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asn[i] == asn);
  endfunction

  function automatic int m_look(int vpn, int asn, output bit from_list);
    from_list = 0;
    foreach (mru[k]) if (m_match(mru[k], vpn, asn)) begin from_list = 1; return mru[k]; end
    for (int i = 0; i < N; i++) if (m_match(i, vpn, asn)) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit fl;
    int e;
    e = m_look(int'(lk_vpn_i), int'(lk_asn_i), fl);
    chk(hit_o == (e >= 0), "hit", int'(hit_o), int'(e >= 0));
    if (e >= 0) begin
      chk(int'(hit_idx_o) == e, "hit_idx", int'(hit_idx_o), e);
      chk(int'(hit_ppn_o) == m_ppn[e], "hit_ppn", int'(hit_ppn_o), m_ppn[e]);
      chk(int'(hit_rmask_o) == m_rm[e], "hit_rmask", int'(hit_rmask_o), m_rm[e]);
    end
    chk(int'(ptr_idx_o) == m_ptr, "ptr_idx", int'(ptr_idx_o), m_ptr);
    chk(ptr_valid_o == m_v[m_ptr], "ptr_valid", int'(ptr_valid_o), int'(m_v[m_ptr]));
    if (m_v[m_ptr])
      chk(int'(ptr_vpn_o) == m_vpn[m_ptr], "ptr_vpn", int'(ptr_vpn_o), m_vpn[m_ptr]);
  endtask

  task automatic model_update();
    bit fl;
    int e;
    bit ins_eff;
    if (!rst_ni) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_ptr = 0;
      mru.delete();
      return;
    end
    e = m_look(int'(lk_vpn_i), int'(lk_asn_i), fl);
    ins_eff = 0;
    if (flush_all_i) begin
      foreach (m_v[i]) begin m_v[i] = 0; m_g[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; end
    end else if (flush_ng_i) begin
      foreach (m_v[i]) if (!m_g[i]) m_v[i] = 0;
    end else if (flush_addr_i) begin
      for (int i = 0; i < N; i++) if (m_match(i, int'(fa_vpn_i), int'(fa_asn_i))) m_v[i] = 0;
    end else if (ins_i) begin
      ins_eff = 1;
      m_v[m_ptr] = 1; m_g[m_ptr] = ins_global_i; m_vpn[m_ptr] = int'(ins_vpn_i);
      m_ppn[m_ptr] = int'(ins_ppn_i); m_asn[m_ptr] = int'(ins_asn_i); m_rm[m_ptr] = int'(ins_rmask_i);
    end
    if (flush_all_i) m_ptr = 0;
    else if (ins_eff || adv_i) m_ptr = (m_ptr + 1) % N;
    if (ins_i || flush_all_i || flush_ng_i || flush_addr_i) mru.delete();
    else if (lk_valid_i && e >= 0 && !fl) begin
      mru.push_front(e);
      if (mru.size() > 3) void'(mru.pop_back());
    end
  endtask

  task automatic tick();
    #1.5;
    compare();
    @(posedge clk);
    model_update();
    #1;
    ins_i = 0; flush_all_i = 0; flush_ng_i = 0; flush_addr_i = 0; adv_i = 0; lk_valid_i = 0;
  endtask

  task automatic set_ins(int vpn, int asn, bit g, int ppn);
    ins_i = 1; ins_vpn_i = VPN_W'(vpn); ins_asn_i = ASN_W'(asn); ins_global_i = g;
    ins_ppn_i = PPN_W'(ppn); ins_rmask_i = N_MODES'(ppn); ins_wmask_i = N_MODES'(~ppn);
    ins_frd_i = ppn[0]; ins_fwr_i = ppn[1];
  endtask

  task automatic do_ins(int vpn, int asn, bit g, int ppn);
    set_ins(vpn, asn, g, ppn);
    tick();
  endtask

  task automatic do_look(int vpn, int asn);
    lk_valid_i = 1; lk_vpn_i = VPN_W'(vpn); lk_asn_i = ASN_W'(asn);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    cur_req = "R10";
    model_update();
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R2: inserts at the pointer, wraparound
    cur_req = "R2";
    for (int i = 0; i < N + 2; i++) do_ins(16 + i, 1, 0, 100 + i);
    do_look(16, 1);
    do_look(25, 1);

    // R1: ASN and global matching
    cur_req = "R3";
    flush_all_i = 1; tick();
    cur_req = "R1";
    do_ins(5, 1, 0, 501);
    do_ins(6, 2, 1, 602);
    do_look(5, 1);
    do_look(5, 2);
    do_look(6, 7);
    do_look(7, 1);

    // R6: list order and duplicates (slot 2 = vpn 9 asn 1, slot 3 = vpn 9 global)
    cur_req = "R6";
    do_ins(9, 1, 0, 901);
    do_ins(9, 3, 1, 902);
    do_look(9, 1);
    do_look(9, 4);
    do_look(9, 1);
    do_look(5, 1);
    do_look(9, 1);
    lk_vpn_i = 9; lk_asn_i = 1; tick();

    // R7: insert empties the list; duplicate resolves to lowest index again
    cur_req = "R7";
    do_ins(40, 0, 0, 40);
    do_look(9, 1);
    do_look(9, 4);
    flush_addr_i = 1; fa_vpn_i = 77; fa_asn_i = 0; tick();
    do_look(9, 1);

    // R8: read-at-pointer and advance
    cur_req = "R8";
    adv_i = 1; tick();
    tick();
    adv_i = 1; set_ins(41, 0, 0, 41); tick();
    for (int i = 0; i < N; i++) begin adv_i = 1; tick(); end

    // R4: flush non-global
    cur_req = "R4";
    flush_ng_i = 1; tick();
    do_look(6, 9);
    do_look(9, 3);
    do_look(9, 1);
    do_look(5, 1);

    // R5: flush one page in one address space
    cur_req = "R5";
    do_ins(12, 1, 0, 121);
    do_ins(12, 2, 0, 122);
    flush_addr_i = 1; fa_vpn_i = 12; fa_asn_i = 2; tick();
    do_look(12, 1);
    do_look(12, 2);
    flush_addr_i = 1; fa_vpn_i = 6; fa_asn_i = 5; tick();
    do_look(6, 0);

    // R9: same-cycle lookup and command priority
    cur_req = "R9";
    lk_valid_i = 1; lk_vpn_i = 12; lk_asn_i = 1; set_ins(50, 0, 0, 50); tick();
    flush_ng_i = 1; set_ins(51, 0, 0, 51); tick();
    do_look(51, 0);
    flush_addr_i = 1; fa_vpn_i = 9; fa_asn_i = 3; set_ins(52, 0, 0, 52); tick();
    do_look(52, 0);
    do_look(9, 3);

    // R3: flush all with an insert pending
    cur_req = "R3";
    do_ins(60, 0, 1, 60);
    flush_all_i = 1; flush_ng_i = 1; set_ins(61, 0, 0, 61); adv_i = 1; tick();
    do_look(60, 0);
    do_look(61, 0);

    // mixed traffic with heavy aliasing
    cur_req = "R6";
    for (int c = 0; c < 4000; c++) begin
      lk_valid_i = ($urandom_range(0, 3) != 0);
      lk_vpn_i = VPN_W'($urandom_range(0, 3));
      lk_asn_i = ASN_W'($urandom_range(0, 2));
      if ($urandom_range(0, 3) == 0)
        set_ins($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 3) == 0,
                $urandom_range(0, 65535));
      if ($urandom_range(0, 15) == 0) begin
        flush_addr_i = 1; fa_vpn_i = VPN_W'($urandom_range(0, 3)); fa_asn_i = ASN_W'($urandom_range(0, 2));
      end
      flush_ng_i  = ($urandom_range(0, 31) == 0);
      flush_all_i = ($urandom_range(0, 63) == 0);
      adv_i       = ($urandom_range(0, 7) == 0);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule